// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time Insertion

This block drives a pair of complementary PWM lines from a single up-counter, for switching the high and low sides of a half-bridge. The counter counts from 1 up to a programmable reload value and then wraps to 1. A compare value sets the point in each period where the primary line takes over from the complementary line. A polarity input selects which logic level counts as "asserted". It also sets the levels the pair rests at while the generator is stopped.

A 3-bit dead-time field delays only the asserting edge of each line. The line being released drops at once. The line about to take over waits the programmed number of clock cycles. During that gap both lines sit at their deasserted level, so the two sides of the bridge are never driven on together. A polarity change made while the counter runs is held back until the next reload, so a period in progress is never cut.

Top module: `cpwm_top`

## Requirements
- R1: While `enable` is low, `pwmOut` equals `polarity` and `pwmOutN` equals its inverse, following `polarity` combinationally. This holds during reset as well.
- R2: While `enable` is high, the counter runs 1, 2, ..., `reloadVal` and then wraps back to 1. The period is therefore `reloadVal` cycles. A value of 1 (or 0) reloads on every cycle. If the count already exceeds a newly lowered reload value, it reloads at once.
- R3: With the latched polarity at 0 and no dead time, `pwmOut` goes high in the cycle after the count equals `compareVal`. It goes low in the cycle after the reload count. `pwmOutN` is always its inverse.
- R4: While running, the two outputs are never both at the asserted level. The asserted level is the inverse of the latched polarity.
- R5: The dead-time field `deadDelay` (0 to 7) delays each asserting edge. After a match or reload, the line that takes over reaches its asserted level `deadDelay` cycles after the deasserting line has dropped. A deasserting edge is never delayed. With `deadDelay` = 0 the outputs are exact complements.
- R6: A change of `polarity` while running has no effect on the outputs until the next reload. At that reload the new polarity is latched.
- R7: A match occurs only when 1 <= `compareVal` < `reloadVal`. If `compareVal` is 0, equals `reloadVal`, or exceeds it, `pwmOut` stays deasserted and `pwmOutN` stays asserted for the whole run.
- R8: With the latched polarity at 1, the levels are mirrored. `pwmOut` goes low after a match and high after a reload. `pwmOutN` does the opposite. The asserted level is low, and the dead time delays falling edges.
- R9: When `enable` rises with `deadDelay` unchanged, `pwmOutN` keeps its idle level without any dead-time gap. `pwmOut` stays at its idle level until the first match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the counter when high; holds idle levels when low |
| polarity | input | 1 | Polarity select: 0 means asserted high, 1 means asserted low |
| reloadVal | input | CNT_W | Last count of each period |
| compareVal | input | CNT_W | Count at which the primary output takes over |
| deadDelay | input | DLY_W | Dead-time in clock cycles applied to each asserting edge |
| pwmOut | output | 1 | Primary PWM output |
| pwmOutN | output | 1 | Complementary PWM output |

## Verification
The bench builds the block with CNT_W = 8 and the default DLY_W = 3. The narrow counter keeps periods short, so many reloads fit into a short run. The full dead-time range 0 to 7 is reachable. This lets the bench set up periods shorter than the dead time, where the primary line never gets to assert. It also covers reload values of 1 and 2, and compare values at 0, at the reload value and beyond it. Polarity flips in mid-period and enable toggling with a nonzero delay are checked cycle by cycle against a behavioural model. The model tracks the cycles since each phase change, not per-line wait counters.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // strobes from the period control to the output datapath
  typedef struct packed {
    logic reloadHit;
    logic matchHit;
  } cpwmStrobe_t;
endpackage

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] compareVal,
  output cpwmStrobe_t      strobe
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count;
  logic             wrapNow;
  logic             hitNow;

  // >= so that a lowered reload value restarts the period immediately
  assign wrapNow = enable && (count >= reloadVal);
  assign hitNow  = enable && !wrapNow && (compareVal != '0) && (count == compareVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= CNT_ONE;
    end else if (!enable || wrapNow) begin
      count <= CNT_ONE;
    end else begin
      count <= count + CNT_ONE;
    end
  end

  assign strobe.reloadHit = wrapNow;
  assign strobe.matchHit  = hitNow;
endmodule

// File: rtl/cpwm_dead.sv
module cpwm_dead #(
  parameter int DLY_W      = 3,
  parameter bit IDLE_READY = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             want,
  input  logic [DLY_W-1:0] delay,
  output logic             gate
);
  localparam logic [DLY_W-1:0] HOLD_MAX = '1;

  logic [DLY_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!enable) begin
      // a line asserted at idle starts already past its dead time
      holdCnt <= IDLE_READY ? delay : '0;
    end else if (!want) begin
      holdCnt <= '0;
    end else if (holdCnt != HOLD_MAX) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // release is immediate; assertion waits until the count reaches the delay
  assign gate = want && (holdCnt >= delay);
endmodule

// File: rtl/cpwm_path.sv
module cpwm_path
  import cpwm_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             polarity,
  input  logic [DLY_W-1:0] delay,
  input  cpwmStrobe_t      strobe,
  output logic             pwmOut,
  output logic             pwmOutN,
  output logic             activePol
);
  localparam int N_CH = 2;

  logic            phase;
  logic [N_CH-1:0] wantVec;
  logic [N_CH-1:0] gate;
  logic [N_CH-1:0] drive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= 1'b0;
      activePol <= 1'b0;
    end else if (!enable) begin
      phase     <= 1'b0;
      activePol <= polarity;
    end else if (strobe.reloadHit) begin
      phase     <= 1'b0;
      activePol <= polarity;
    end else if (strobe.matchHit) begin
      phase     <= 1'b1;
    end
  end

  assign wantVec[0] = phase;
  assign wantVec[1] = ~phase;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    localparam bit IDLE_READY = (ch == 1);
    cpwm_dead #(
      .DLY_W(DLY_W),
      .IDLE_READY(IDLE_READY)
    ) u_dead (
      .clk   (clk),
      .rstN  (rstN),
      .enable(enable),
      .want  (wantVec[ch]),
      .delay (delay),
      .gate  (gate[ch])
    );
    // asserted level is the inverse of the latched polarity
    assign drive[ch] = enable ? (activePol ^ gate[ch]) : (polarity ^ IDLE_READY);
  end

  assign pwmOut  = drive[0];
  assign pwmOutN = drive[1];
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             polarity,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] compareVal,
  input  logic [DLY_W-1:0] deadDelay,
  output logic             pwmOut,
  output logic             pwmOutN
);
  cpwmStrobe_t strobe;
  logic        activePol;
  logic        reloadHit;

  cpwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .reloadVal (reloadVal),
    .compareVal(compareVal),
    .strobe    (strobe)
  );

  cpwm_path #(.DLY_W(DLY_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .polarity (polarity),
    .delay    (deadDelay),
    .strobe   (strobe),
    .pwmOut   (pwmOut),
    .pwmOutN  (pwmOutN),
    .activePol(activePol)
  );

  assign reloadHit = strobe.reloadHit;
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             polarity,
  input logic [DLY_W-1:0] deadDelay,
  input logic             pwmOut,
  input logic             pwmOutN,
  input logic             activePol,
  input logic             reloadHit
);
  // R1: idle levels follow the polarity input
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (pwmOut == polarity && pwmOutN == !polarity));

  // R4: never both at the asserted level
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> !(pwmOut != activePol && pwmOutN != activePol));

  // R5: zero dead time gives exact complements
  p_zero_dead_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && deadDelay == '0) |-> (pwmOut != pwmOutN));

  // R6: latched polarity only moves on a reload while running
  p_pol_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !$past(reloadHit)) |-> $stable(activePol));
endmodule

bind cpwm_top cpwm_checker #(.DLY_W(DLY_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .polarity (polarity),
  .deadDelay(deadDelay),
  .pwmOut   (pwmOut),
  .pwmOutN  (pwmOutN),
  .activePol(activePol),
  .reloadHit(reloadHit)
);

// File: tb/cpwm_top_tb.sv
module cpwm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DLY_W = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             enable;
  logic             polarity;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] compareVal;
  logic [DLY_W-1:0] deadDelay;
  logic             pwmOut;
  logic             pwmOutN;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  // behavioural model state
  int mCount, mPhase, mPol, mSince;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_top #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .polarity(polarity),
    .reloadVal(reloadVal), .compareVal(compareVal), .deadDelay(deadDelay),
    .pwmOut(pwmOut), .pwmOutN(pwmOutN)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 1; mPhase = 0; mPol = 0; mSince = 99;
    end else if (!enable) begin
      mCount = 1; mPhase = 0; mPol = int'(polarity); mSince = 99;
    end else begin
      bit wrapped, hit;
      int nph;
      wrapped = (mCount >= int'(reloadVal));
      hit = !wrapped && (compareVal != 0) && (mCount == int'(compareVal));
      nph = wrapped ? 0 : (hit ? 1 : mPhase);
      if (wrapped) mPol = int'(polarity);
      if (nph != mPhase) mSince = 0;
      else if (mSince < 1000) mSince = mSince + 1;
      mPhase = nph;
      mCount = wrapped ? 1 : mCount + 1;
    end
  end

  task automatic compareNow();
    logic expO, expN;
    bit assO, assN;
    if (!enable) begin
      expO = polarity; expN = ~polarity;
    end else begin
      assO = (mPhase == 1) && (mSince >= int'(deadDelay));
      assN = (mPhase == 0) && (mSince >= int'(deadDelay));
      expO = assO ? ~mPol[0] : mPol[0];
      expN = assN ? ~mPol[0] : mPol[0];
    end
    total++;
    if (pwmOut !== expO || pwmOutN !== expN) begin
      bad++;
      $display("FAIL %s t=%0t out/outN actual=%b%b expected=%b%b",
               curReq, $time, pwmOut, pwmOutN, expO, expN);
    end
    if (enable) begin
      total++;
      if (pwmOut !== mPol[0] && pwmOutN !== mPol[0] && pwmOut !== 1'bx) begin
        bad++;
        $display("FAIL R4 t=%0t both asserted actual=%b%b expected not both %b",
                 $time, pwmOut, pwmOutN, ~mPol[0]);
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareNow();
    end
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; polarity = 1'b0;
    reloadVal = 8'd6; compareVal = 8'd3; deadDelay = 3'd0;
    // R1: reset state
    curReq = "R1";
    run(3);
    polarity = 1'b1;
    run(2);
    rstN = 1'b1;
    run(5);
    polarity = 1'b0;
    run(5);

    // R3: polarity 0, no dead time
    curReq = "R3";
    enable = 1'b1;
    run(30);

    // R2: tiny periods and a lowered reload in mid-run
    curReq = "R2";
    reloadVal = 8'd2; compareVal = 8'd1;
    run(12);
    reloadVal = 8'd1;
    run(8);
    reloadVal = 8'd9; compareVal = 8'd4;
    run(6);
    reloadVal = 8'd3; compareVal = 8'd1;
    run(12);

    // R5: dead times of several lengths
    curReq = "R5";
    enable = 1'b0;
    run(2);
    deadDelay = 3'd2; reloadVal = 8'd10; compareVal = 8'd4;
    run(2);
    enable = 1'b1;
    run(40);
    enable = 1'b0;
    deadDelay = 3'd7; reloadVal = 8'd20; compareVal = 8'd8;
    run(2);
    enable = 1'b1;
    run(60);
    enable = 1'b0;
    deadDelay = 3'd5; reloadVal = 8'd8; compareVal = 8'd6;
    run(2);
    enable = 1'b1;
    run(30);

    // R8: polarity 1 mirrored levels
    curReq = "R8";
    enable = 1'b0; polarity = 1'b1;
    deadDelay = 3'd3; reloadVal = 8'd9; compareVal = 8'd5;
    run(3);
    enable = 1'b1;
    run(40);

    // R6: polarity flips while running wait for the reload
    curReq = "R6";
    deadDelay = 3'd1;
    run(2);
    polarity = 1'b0;
    run(3);
    polarity = 1'b1;
    run(2);
    polarity = 1'b0;
    run(30);

    // R7: compare out of range
    curReq = "R7";
    reloadVal = 8'd7; compareVal = 8'd0;
    run(30);
    compareVal = 8'd9;
    run(30);
    compareVal = 8'd7;
    run(30);

    // R9: enable toggling with dead time
    curReq = "R9";
    enable = 1'b0; deadDelay = 3'd4; compareVal = 8'd3; reloadVal = 8'd12;
    run(3);
    enable = 1'b1;
    run(20);
    enable = 1'b0;
    run(5);
    polarity = 1'b1;
    run(2);
    enable = 1'b1;
    run(30);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule